// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block is the control engine of one DMA channel. It follows a chain of transfer descriptors kept in memory and turns each data descriptor into a single command for a separate data mover. The data mover moves the payload. Software sets the list start address and the channel and list enables. It loads the consumer cycle state and then pulses the doorbell. From there the walker reads descriptors one 32-bit word at a time through a request/response memory port. It issues source, destination and size on a valid/ready command port, waits for the mover's completion and steps on to the next element.

Ownership is decided per element. The element's cycle bit is compared with the walker's consumer cycle state, and an element whose bit does not match ends the run cleanly. Link elements redirect the walk to a new address and can invert the consumer cycle state. A list is therefore usually closed by a toggling link that points back to its own head. Each data element can ask for a stop event on completion. A mover error or a loss of channel enable ends the run with an abort event.

Top module: `llw_walker`

## Requirements
- R1: After reset, status reads 3 (stopped), cycle_state is 0, and mem_req, mv_valid, stop_evt and abort_evt are all low.
- R2: A doorbell pulse seen while the walker is idle starts a run only if ch_enable and ll_enable are both high. Status then becomes 1 (running) and the first read goes to list_base. Otherwise the doorbell leaves status and the memory port untouched.
- R3: Descriptor words are read as 32-bit words at byte offset 4*i from the element address, with word i in 0..5. At most one read is outstanding. A new mem_req is never raised before the previous response.
- R4: A data element has control in word 0, size in word 1, source low/high in words 2/3 and destination low/high in words 4/5. It produces one command with those values. mv_valid and the values stay steady until mv_ready, and commands leave in list order.
- R5: Control bit 0 is the element's cycle bit. If it differs from cycle_state, the walker consumes nothing, sets status 3, pulses stop_evt and goes idle.
- R6: Control bit 2 marks a link element, whose next-element address is word 3:word 2. The walker continues there. If control bit 1 is also set, cycle_state is inverted.
- R7: After a data element completes, the next element address is the current one plus 24 bytes.
- R8: When the mover completes a data element without error and that element has control bit 3 or bit 4 set, stop_evt pulses for one cycle and the walk continues.
- R9: A mover completion with mv_err high ends the run: status 2, one abort_evt pulse, no further commands.
- R10: ch_enable low while running ends the run on the next edge: status 2, one abort_evt pulse, walker idle.
- R11: A cycle-sync write while idle loads cycle_state with cyc_sync_val.
- R12: Status only takes the codes 1, 2 or 3, and stop_evt and abort_evt never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 1 | Channel enable level |
| ll_enable | input | 1 | Linked-list mode enable level |
| list_base | input | 64 | Address of the first list element |
| cyc_sync_wr | input | 1 | Pulse: load the consumer cycle state |
| cyc_sync_val | input | 1 | Value loaded by cyc_sync_wr |
| doorbell | input | 1 | Pulse: start walking the list |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response word |
| mv_valid | output | 1 | Mover command valid |
| mv_ready | input | 1 | Mover accepts command |
| mv_src | output | 64 | Command source address |
| mv_dst | output | 64 | Command destination address |
| mv_size | output | 32 | Command transfer size in bytes |
| mv_done | input | 1 | Mover completion strobe |
| mv_err | input | 1 | Completion carries an error (valid with mv_done) |
| status | output | 2 | 1 running, 2 error, 3 stopped |
| cycle_state | output | 1 | Consumer cycle state |
| stop_evt | output | 1 | Stop event pulse |
| abort_evt | output | 1 | Abort event pulse |

## Verification
The assertions take two things for granted about the memory side. Every read request gets exactly one response strobe, and a response is never delivered without a request. They also assume mv_done arrives only for a command that was accepted. The bench's memory model replies to each request after a fixed latency. Its mover model completes each accepted command once. After an abandoned run it waits long enough for any late response to drain before the next doorbell, so no stale word can reach a new run. The sweep covers both starting cycle states, chains of one to four data elements, links with and without toggle, and a mover that stalls on alternate cycles.

// File: rtl/llw_pkg.sv
// Shared constants for the linked-list descriptor walker.
// Assumes a 64-bit address space and 32-bit descriptor words.
package llw_pkg;
    parameter int unsigned ADDR_W      = 64;
    parameter int unsigned WORD_W      = 32;
    parameter int unsigned DESC_WORDS  = 6;
    parameter int unsigned WORD_BYTES  = WORD_W / 8;
    parameter int unsigned STRIDE      = DESC_WORDS * WORD_BYTES;
    parameter int unsigned IDX_W       = $clog2(DESC_WORDS);
    parameter int unsigned SIZE_W      = WORD_W;

    // control word bit positions (decoded by the walker)
    parameter int unsigned OWN_BIT   = 0;
    parameter int unsigned FLIP_BIT  = 1;
    parameter int unsigned LINK_BIT  = 2;
    parameter int unsigned IRQ_L_BIT = 3;
    parameter int unsigned IRQ_R_BIT = 4;

    // status codes
    localparam logic [1:0] ST_RUN  = 2'd1;
    localparam logic [1:0] ST_ERR  = 2'd2;
    localparam logic [1:0] ST_DONE = 2'd3;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH0, W_CTRL, W_LINK, W_BODY, W_CMD, W_WAIT
    } walk_state_e;
endpackage

// File: rtl/llw_fetch.sv
// Descriptor word fetcher.
// Reads words first_idx..last_idx of one element, one request at a time,
// and pulses done once the last word has arrived. Assumes every request is
// answered by exactly one response; flush abandons the sequence.
module llw_fetch
    import llw_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               flush,
    input  logic [ADDR_W-1:0]                  elem_addr,
    input  logic [IDX_W-1:0]                   first_idx,
    input  logic [IDX_W-1:0]                   last_idx,
    output logic                               mem_req,
    output logic [ADDR_W-1:0]                  mem_addr,
    input  logic                               mem_rsp_valid,
    input  logic [WORD_W-1:0]                  mem_rsp_data,
    output logic                               done,
    output logic [DESC_WORDS-1:0][WORD_W-1:0]  words
);
    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_q;
    logic [ADDR_W-1:0] base_q;
    logic              take;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] b,
                                                    input logic [IDX_W-1:0] i);
        return b + ADDR_W'({i, 2'b00});
    endfunction

    assign take = busy && mem_rsp_valid && !flush;

    // Sequence the reads: one request, wait for its response, then the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= '0;
            last_q   <= '0;
            base_q   <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
        end else begin
            mem_req <= 1'b0;
            done    <= 1'b0;
            if (flush) begin
                busy <= 1'b0;
            end else if (start) begin
                busy     <= 1'b1;
                idx      <= first_idx;
                last_q   <= last_idx;
                base_q   <= elem_addr;
                mem_req  <= 1'b1;
                mem_addr <= word_addr(elem_addr, first_idx);
            end else if (take) begin
                if (idx == last_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx      <= idx + 1'b1;
                    mem_req  <= 1'b1;
                    mem_addr <= word_addr(base_q, idx + 1'b1);
                end
            end
        end
    end

    // One capture register per descriptor word.
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (take && !start && idx == IDX_W'(g))
                words[g] <= mem_rsp_data;
        end
    end
endmodule

// File: rtl/llw_seq.sv
// Walk sequencer.
// Decides ownership, follows links, issues mover commands, and owns status,
// cycle state and the event pulses. Assumes fetch words stay valid until the
// next fetch of the same index; word 0 is only refetched at a new element.
module llw_seq
    import llw_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ch_enable,
    input  logic                               ll_enable,
    input  logic [ADDR_W-1:0]                  list_base,
    input  logic                               cyc_sync_wr,
    input  logic                               cyc_sync_val,
    input  logic                               doorbell,
    input  logic                               fetch_done,
    input  logic [DESC_WORDS-1:0][WORD_W-1:0]  words,
    output logic                               fetch_start,
    output logic                               fetch_flush,
    output logic [ADDR_W-1:0]                  fetch_addr,
    output logic [IDX_W-1:0]                   first_idx,
    output logic [IDX_W-1:0]                   last_idx,
    output logic                               mv_valid,
    input  logic                               mv_ready,
    output logic [ADDR_W-1:0]                  mv_src,
    output logic [ADDR_W-1:0]                  mv_dst,
    output logic [SIZE_W-1:0]                  mv_size,
    input  logic                               mv_done,
    input  logic                               mv_err,
    output logic [1:0]                         status,
    output logic                               cycle_state,
    output logic                               stop_evt,
    output logic                               abort_evt
);
    walk_state_e       state;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] ctl;
    logic              owned;
    logic              is_link;

    assign ctl     = words[0];
    assign owned   = (ctl[OWN_BIT] == cycle_state);
    assign is_link = ctl[LINK_BIT];

    // Fetch requests: word 0 of a new element, then body or link pointer.
    always_comb begin
        fetch_flush = (state != W_IDLE) && !ch_enable;
        fetch_start = !fetch_flush &&
                      ((state == W_FETCH0) || (state == W_CTRL && fetch_done && owned));
        fetch_addr  = cur_addr;
        first_idx   = '0;
        last_idx    = '0;
        if (state == W_CTRL) begin
            first_idx = is_link ? IDX_W'(2) : IDX_W'(1);
            last_idx  = is_link ? IDX_W'(3) : IDX_W'(DESC_WORDS - 1);
        end
    end

    // Mover command fields come straight from the captured words.
    assign mv_valid = (state == W_CMD);
    assign mv_size  = words[1];
    assign mv_src   = {words[3], words[2]};
    assign mv_dst   = {words[5], words[4]};

    // Walk state machine with status, cycle state and events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= W_IDLE;
            cur_addr    <= '0;
            cycle_state <= 1'b0;
            status      <= ST_DONE;
            stop_evt    <= 1'b0;
            abort_evt   <= 1'b0;
        end else begin
            stop_evt  <= 1'b0;
            abort_evt <= 1'b0;
            if (fetch_flush) begin
                state     <= W_IDLE;
                status    <= ST_ERR;
                abort_evt <= 1'b1;
            end else begin
                case (state)
                    W_IDLE: begin
                        if (cyc_sync_wr)
                            cycle_state <= cyc_sync_val;
                        if (doorbell && ch_enable && ll_enable) begin
                            cur_addr <= list_base;
                            status   <= ST_RUN;
                            state    <= W_FETCH0;
                        end
                    end
                    W_FETCH0: state <= W_CTRL;
                    W_CTRL: begin
                        if (fetch_done) begin
                            if (!owned) begin
                                state    <= W_IDLE;
                                status   <= ST_DONE;
                                stop_evt <= 1'b1;
                            end else begin
                                state <= is_link ? W_LINK : W_BODY;
                            end
                        end
                    end
                    W_LINK: begin
                        if (fetch_done) begin
                            cur_addr <= {words[3], words[2]};
                            if (ctl[FLIP_BIT])
                                cycle_state <= ~cycle_state;
                            state <= W_FETCH0;
                        end
                    end
                    W_BODY: if (fetch_done) state <= W_CMD;
                    W_CMD:  if (mv_ready) state <= W_WAIT;
                    W_WAIT: begin
                        if (mv_done) begin
                            if (mv_err) begin
                                state     <= W_IDLE;
                                status    <= ST_ERR;
                                abort_evt <= 1'b1;
                            end else begin
                                stop_evt <= ctl[IRQ_L_BIT] | ctl[IRQ_R_BIT];
                                cur_addr <= cur_addr + ADDR_W'(STRIDE);
                                state    <= W_FETCH0;
                            end
                        end
                    end
                    default: state <= W_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/llw_walker.sv
// Linked-list descriptor walker, top level.
// Joins the word fetcher and the walk sequencer for one DMA channel.
// Assumes a memory port that answers every request once, and a data mover
// that completes every accepted command once.
module llw_walker
    import llw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_enable,
    input  logic              ll_enable,
    input  logic [63:0]       list_base,
    input  logic              cyc_sync_wr,
    input  logic              cyc_sync_val,
    input  logic              doorbell,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              mv_valid,
    input  logic              mv_ready,
    output logic [63:0]       mv_src,
    output logic [63:0]       mv_dst,
    output logic [31:0]       mv_size,
    input  logic              mv_done,
    input  logic              mv_err,
    output logic [1:0]        status,
    output logic              cycle_state,
    output logic              stop_evt,
    output logic              abort_evt
);
    logic                              f_start;
    logic                              f_flush;
    logic                              f_done;
    logic [ADDR_W-1:0]                 f_addr;
    logic [IDX_W-1:0]                  f_first;
    logic [IDX_W-1:0]                  f_last;
    logic [DESC_WORDS-1:0][WORD_W-1:0] f_words;

    llw_fetch u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (f_start),
        .flush         (f_flush),
        .elem_addr     (f_addr),
        .first_idx     (f_first),
        .last_idx      (f_last),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (f_done),
        .words         (f_words)
    );

    llw_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_enable    (ch_enable),
        .ll_enable    (ll_enable),
        .list_base    (list_base),
        .cyc_sync_wr  (cyc_sync_wr),
        .cyc_sync_val (cyc_sync_val),
        .doorbell     (doorbell),
        .fetch_done   (f_done),
        .words        (f_words),
        .fetch_start  (f_start),
        .fetch_flush  (f_flush),
        .fetch_addr   (f_addr),
        .first_idx    (f_first),
        .last_idx     (f_last),
        .mv_valid     (mv_valid),
        .mv_ready     (mv_ready),
        .mv_src       (mv_src),
        .mv_dst       (mv_dst),
        .mv_size      (mv_size),
        .mv_done      (mv_done),
        .mv_err       (mv_err),
        .status       (status),
        .cycle_state  (cycle_state),
        .stop_evt     (stop_evt),
        .abort_evt    (abort_evt)
    );
endmodule

// File: rtl/llw_walker_chk.sv
// Property checker for llw_walker, attached by bind.
// Assumes each mem_req is answered by exactly one mem_rsp_valid.
module llw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ch_enable,
    input logic        ll_enable,
    input logic        doorbell,
    input logic        mem_req,
    input logic        mem_rsp_valid,
    input logic        mv_valid,
    input logic        mv_ready,
    input logic [63:0] mv_src,
    input logic [63:0] mv_dst,
    input logic [31:0] mv_size,
    input logic [1:0]  status,
    input logic        stop_evt,
    input logic        abort_evt
);
    logic pend;

    // Track whether a read is waiting for its response.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (mem_req)
            pend <= 1'b1;
        else if (mem_rsp_valid)
            pend <= 1'b0;
    end

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend);

    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_ready && ch_enable) |=>
            (mv_valid && $stable(mv_src) && $stable(mv_dst) && $stable(mv_size)));

    p_cmd_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> (status == 2'd1));

    p_doorbell_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (doorbell && !(ch_enable && ll_enable) && status != 2'd1) |=>
            (status == $past(status)));

    p_disable_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_enable && status == 2'd1) |=> (abort_evt && status == 2'd2));

    p_status_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd0);

    p_evt_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_evt && abort_evt));
endmodule

bind llw_walker llw_walker_chk u_chk (.*);

// File: tb/llw_walker_bench.sv
// Self-checking bench for llw_walker: sweeps chain lengths, cycle states,
// link kinds and mover stalls, then error, disable and ignored-doorbell cases.
module llw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_enable = 1'b0, ll_enable = 1'b0;
    logic [63:0] list_base = 64'h40;
    logic        cyc_sync_wr = 1'b0, cyc_sync_val = 1'b0, doorbell = 1'b0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mv_valid, mv_ready = 1'b1;
    logic [63:0] mv_src, mv_dst;
    logic [31:0] mv_size;
    logic        mv_done = 1'b0, mv_err = 1'b0;
    logic [1:0]  status;
    logic        cycle_state, stop_evt, abort_evt;

    llw_walker u_llw_walker (.*);

    always #10 clk = ~clk;

    logic [31:0] mem [0:255];
    logic [63:0] log_src [0:7];
    logic [63:0] log_dst [0:7];
    logic [31:0] log_size [0:7];
    int n_chk = 0, n_err = 0;
    int req_cnt = 0, cmd_cnt = 0, stop_cnt = 0, abort_cnt = 0;
    int mem_lat = 0, mv_lat = 0, err_at = 99, rd_idx = 0, cycles = 0;
    bit stall = 1'b0, pend_err = 1'b0;

    // Memory and mover models plus event counters, all at the falling edge.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (mem_lat > 0) begin
            mem_lat--;
            if (mem_lat == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[rd_idx];
            end
        end
        if (mem_req) begin
            mem_lat = 2;
            rd_idx  = int'(mem_addr[9:2]);
            req_cnt++;
        end
        mv_done = 1'b0;
        mv_err  = 1'b0;
        if (mv_lat > 0) begin
            mv_lat--;
            if (mv_lat == 0) begin
                mv_done = 1'b1;
                mv_err  = pend_err;
            end
        end
        mv_ready = stall ? ~mv_ready : 1'b1;
        if (mv_valid && mv_ready) begin
            if (cmd_cnt < 8) begin
                log_src[cmd_cnt]  = mv_src;
                log_dst[cmd_cnt]  = mv_dst;
                log_size[cmd_cnt] = mv_size;
            end
            pend_err = (cmd_cnt == err_at);
            cmd_cnt++;
            mv_lat = 3;
        end
        if (stop_evt)  stop_cnt++;
        if (abort_evt) abort_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] src_of(int k, int n);
        return {32'(k + 1), 32'h1000_0000 + 32'(k * 16 + n)};
    endfunction
    function automatic logic [63:0] dst_of(int k, int n);
        return {32'(8'hC0 + k), 32'h2000_0000 + 32'(k * 256 + n)};
    endfunction
    function automatic logic [31:0] size_of(int k, int n);
        return 32'(256 * (k + 1) + n);
    endfunction

    // Build n data elements at 0x40 followed by one link element.
    task automatic build(input bit c, input int n, input bit tog, output int irqs);
        irqs = 0;
        for (int k = 0; k < n; k++) begin
            int w = 16 + 6 * k;
            bit lie = ((k + n) % 2) == 1;
            bit rie = (k == 0) && c;
            if (lie || rie) irqs++;
            mem[w]     = {27'd0, rie, lie, 2'b00, c};
            mem[w + 1] = size_of(k, n);
            mem[w + 2] = src_of(k, n)[31:0];
            mem[w + 3] = src_of(k, n)[63:32];
            mem[w + 4] = dst_of(k, n)[31:0];
            mem[w + 5] = dst_of(k, n)[63:32];
        end
        mem[16 + 6 * n]     = {29'd0, 1'b1, tog, c};
        mem[16 + 6 * n + 1] = 32'd0;
        mem[16 + 6 * n + 2] = tog ? 32'h40 : 32'h300;
        mem[16 + 6 * n + 3] = 32'd0;
        mem[192] = {31'd0, ~c};
    endtask

    task automatic start_run(input bit c);
        req_cnt = 0; cmd_cnt = 0; stop_cnt = 0; abort_cnt = 0;
        @(negedge clk); cyc_sync_val = c; cyc_sync_wr = 1'b1;
        @(negedge clk); cyc_sync_wr = 1'b0; doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
    endtask

    task automatic wait_end();
        int g = 0;
        while (status == 2'd1 && g < 3000) begin
            @(negedge clk);
            g++;
        end
        repeat (8) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int irqs;
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 2'd3, "R1", "status", 64'(status), 64'd3);
        chk(cycle_state == 1'b0, "R1", "cycle_state", 64'(cycle_state), 64'd0);
        chk(!mem_req && !mv_valid && !stop_evt && !abort_evt, "R1", "outputs idle",
            64'({mem_req, mv_valid, stop_evt, abort_evt}), 64'd0);

        ch_enable = 1'b1; ll_enable = 1'b1;
        // Sweep: cycle state, chain length, link kind; alternate stalls.
        for (int c = 0; c < 2; c++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int t = 0; t < 2; t++) begin
                    stall = (n % 2) == 1;
                    build(c[0], n, t[0], irqs);
                    start_run(c[0]);
                    wait_end();
                    chk(cmd_cnt == n, "R4", "command count", 64'(cmd_cnt), 64'(n));
                    for (int k = 0; k < n; k++) begin
                        chk(log_src[k] == src_of(k, n) && log_dst[k] == dst_of(k, n)
                            && log_size[k] == size_of(k, n), "R7", "command fields",
                            log_src[k], src_of(k, n));
                    end
                    chk(req_cnt == 6 * n + 4, "R3", "word reads", 64'(req_cnt),
                        64'(6 * n + 4));
                    chk(status == 2'd3, "R5", "final status", 64'(status), 64'd3);
                    chk(cycle_state == (t[0] ? ~c[0] : c[0]), "R6", "cycle_state after link",
                        64'(cycle_state), 64'(t[0] ? ~c[0] : c[0]));
                    chk(stop_cnt == irqs + 1, "R8", "stop events", 64'(stop_cnt),
                        64'(irqs + 1));
                    chk(abort_cnt == 0, "R12", "no abort", 64'(abort_cnt), 64'd0);
                end
            end
        end
        stall = 1'b0;

        // R5: first element not owned
        mem[16] = 32'd1;
        start_run(1'b0);
        wait_end();
        chk(cmd_cnt == 0 && req_cnt == 1, "R5", "unowned head reads/commands",
            64'(cmd_cnt * 16 + req_cnt), 64'd1);
        chk(stop_cnt == 1 && status == 2'd3, "R5", "unowned head stop",
            64'(stop_cnt * 4 + int'(status)), 64'd7);

        // R9: mover error on the second command
        build(1'b0, 3, 1'b1, irqs);
        err_at = 1;
        start_run(1'b0);
        wait_end();
        err_at = 99;
        chk(cmd_cnt == 2, "R9", "commands before error", 64'(cmd_cnt), 64'd2);
        chk(status == 2'd2 && abort_cnt == 1, "R9", "error status/abort",
            64'(int'(status) * 4 + abort_cnt), 64'd9);

        // R10: disable during a run
        build(1'b1, 4, 1'b1, irqs);
        start_run(1'b1);
        begin
            int g = 0;
            while (cmd_cnt < 1 && g < 2000) begin @(negedge clk); g++; end
        end
        ch_enable = 1'b0;
        repeat (20) @(negedge clk);
        chk(status == 2'd2, "R10", "status after disable", 64'(status), 64'd2);
        chk(abort_cnt == 1, "R10", "abort on disable", 64'(abort_cnt), 64'd1);

        // R2: doorbell with enable low is ignored
        req_cnt = 0;
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
        repeat (10) @(negedge clk);
        chk(status == 2'd2 && req_cnt == 0, "R2", "doorbell with enable low",
            64'(int'(status) * 16 + req_cnt), 64'd32);

        // R11: cycle-sync while idle
        @(negedge clk); cyc_sync_val = 1'b1; cyc_sync_wr = 1'b1;
        @(negedge clk); cyc_sync_wr = 1'b0;
        chk(cycle_state == 1'b1, "R11", "cycle sync load 1", 64'(cycle_state), 64'd1);
        @(negedge clk); cyc_sync_val = 1'b0; cyc_sync_wr = 1'b1;
        @(negedge clk); cyc_sync_wr = 1'b0;
        chk(cycle_state == 1'b0, "R11", "cycle sync load 0", 64'(cycle_state), 64'd0);

        // R2: doorbell with list mode off is ignored
        ch_enable = 1'b1; ll_enable = 1'b0; req_cnt = 0;
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
        repeat (10) @(negedge clk);
        chk(status == 2'd2 && req_cnt == 0, "R2", "doorbell with list mode off",
            64'(int'(status) * 16 + req_cnt), 64'd32);

        // R2: a valid doorbell starts at list_base
        ll_enable = 1'b1;
        build(1'b0, 1, 1'b1, irqs);
        start_run(1'b0);
        chk(status == 2'd1, "R2", "running after doorbell", 64'(status), 64'd1);
        wait_end();
        chk(cmd_cnt == 1 && log_src[0] == src_of(0, 1), "R2", "run from base",
            log_src[0], src_of(0, 1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule